// File: doc/BRIEF.md
# Magnitude Threshold Crossing Detector

This block watches one of two signed line measurements, the line voltage or the line current, and flags the moment its magnitude crosses a programmable unsigned threshold. A source-select input picks the measurement. A direction input picks whether the flag marks a rise above the threshold or a fall back to or below it. Measurements arrive with a valid strobe, and only strobed samples are compared.

The output is a one-cycle event pulse meant for an interrupt controller. An event needs two consecutive valid samples on opposite sides of the threshold. A value that stays beyond the threshold raises nothing more. Changing the source or the direction discards the remembered side, so a reconfiguration never produces a spurious event.

Top module: `xing_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `cross_evt` is 0.
- R2: `src_sel` = 0 compares `volt_meas`; `src_sel` = 1 compares `curr_meas`. The unselected measurement has no effect on `cross_evt`.
- R3: The magnitude (absolute value) of the selected two's-complement measurement is compared, so -51 and +51 give the same result.
- R4: With `dir_fall` = 0, a valid sample whose magnitude is above `thresh` raises `cross_evt` on the cycle after that sample, provided the previous valid sample was not above it.
- R5: With `dir_fall` = 1, a valid sample whose magnitude is not above `thresh` raises `cross_evt` on the cycle after that sample, provided the previous valid sample was above it.
- R6: Cycles with `meas_valid` = 0 are ignored: they raise no event and leave the remembered side unchanged. A value that stays on one side raises no event.
- R7: The magnitude of -128 saturates to 127.
- R8: A magnitude equal to `thresh` counts as not above it. A threshold of 128 or more is never exceeded.
- R9: A change of `src_sel` or `dir_fall` from its value in the previous cycle clears the remembered side. The next valid sample only sets a new reference and raises no event.
- R10: `cross_evt` is high for exactly one cycle per crossing.
- R11: The first valid sample after reset raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_valid | input | 1 | Strobe marking a new measurement pair |
| volt_meas | input | 8 | Signed line-voltage measurement |
| curr_meas | input | 8 | Signed line-current measurement |
| src_sel | input | 1 | 0 selects voltage, 1 selects current |
| thresh | input | 8 | Unsigned magnitude threshold |
| dir_fall | input | 1 | 0 flags a rise above the threshold, 1 flags a fall to or below it |
| cross_evt | output | 1 | One-cycle crossing event |

## Verification
The stimulus walks the selected value up through the threshold, and through it again from the negative side, to separate magnitude comparison from signed comparison. It then holds the value beyond the threshold and inserts invalid cycles, to show that the event is edge-based and that the remembered side survives idle cycles. A threshold exactly equal to the magnitude, and a measurement of -128 against thresholds of 126 and 127, separate a strict compare and a saturating absolute value from their off-by-one variants. Large values are placed on the unselected input while the selected input stays quiet, and source and direction are switched at moments when a stale reference would fire, so a missing history clear or a wrong multiplexer shows up as an extra event.

// File: rtl/xing_pkg.sv
package xing_pkg;

    localparam int MEAS_W = 8;
    localparam int THR_W  = 8;
    localparam int N_SRC  = 2;

    typedef enum logic {
        SRC_VOLT = 1'b0,
        SRC_CURR = 1'b1
    } src_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } dir_e;

    typedef struct packed {
        logic hist_vld;
        logic above;
        logic sel;
        logic dir;
        logic evt;
    } trk_state_t;

endpackage

// File: rtl/xing_mag.sv
module xing_mag #(
    parameter int IN_W = 8
) (
    input  logic signed [IN_W-1:0] din,
    output logic        [IN_W-2:0] mag
);
    localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};

    logic [IN_W-1:0] neg_v;

    always_comb begin
        neg_v = -din;
        if (!din[IN_W-1]) begin
            mag = din[IN_W-2:0];
        end else if (din == MOST_NEG) begin
            mag = '1;
        end else begin
            mag = neg_v[IN_W-2:0];
        end
    end

    always_comb begin
        if (din == MOST_NEG) begin
            a_sat_r7: assert (mag == {(IN_W-1){1'b1}});
        end
    end

endmodule

// File: rtl/xing_track.sv
module xing_track
    import xing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic sel_i,
    input  logic dir_i,
    input  logic above_i,
    output logic evt_o
);
    trk_state_t st_d, st_q;
    logic       cfg_chg;

    always_comb begin
        cfg_chg = (sel_i != st_q.sel) || (dir_i != st_q.dir);
        st_d     = st_q;
        st_d.sel = sel_i;
        st_d.dir = dir_i;
        st_d.evt = 1'b0;
        if (cfg_chg) begin
            st_d.hist_vld = 1'b0;
        end
        if (valid_i) begin
            st_d.above    = above_i;
            st_d.hist_vld = 1'b1;
            if (!cfg_chg && st_q.hist_vld) begin
                if (dir_i == DIR_FALL) begin
                    st_d.evt = st_q.above && !above_i;
                end else begin
                    st_d.evt = !st_q.above && above_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hist_vld: 1'b0, above: 1'b0, sel: SRC_VOLT,
                      dir: DIR_RISE, evt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

    p_evt_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> $past(valid_i));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);

    p_cfg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ((sel_i != st_q.sel) || (dir_i != st_q.dir))) |=> !st_q.evt);

    p_first_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !st_q.hist_vld) |=> !st_q.evt);

    p_rise_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.evt && (st_q.dir == DIR_RISE)) |-> st_q.above);

    p_fall_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.evt && (st_q.dir == DIR_FALL)) |-> !st_q.above);

endmodule

// File: rtl/xing_detect.sv
module xing_detect
    import xing_pkg::*;
#(
    parameter int DATA_W = MEAS_W,
    parameter int TH_W   = THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [DATA_W-1:0] volt_meas,
    input  logic [DATA_W-1:0] curr_meas,
    input  logic              src_sel,
    input  logic [TH_W-1:0]   thresh,
    input  logic              dir_fall,
    output logic              cross_evt
);
    localparam int MAG_W = DATA_W - 1;
    localparam int CMP_W = (MAG_W > TH_W) ? MAG_W : TH_W;

    logic [DATA_W-1:0] src_raw [N_SRC];
    logic [MAG_W-1:0]  src_mag [N_SRC];
    logic [MAG_W-1:0]  sel_mag;
    logic [CMP_W-1:0]  mag_ext;
    logic [CMP_W-1:0]  thr_ext;
    logic              above;

    assign src_raw[SRC_VOLT] = volt_meas;
    assign src_raw[SRC_CURR] = curr_meas;

    for (genvar g = 0; g < N_SRC; g++) begin : g_mag
        xing_mag #(.IN_W(DATA_W)) u_mag (
            .din (src_raw[g]),
            .mag (src_mag[g])
        );
    end

    always_comb begin
        sel_mag = src_sel ? src_mag[SRC_CURR] : src_mag[SRC_VOLT];
        mag_ext = CMP_W'(sel_mag);
        thr_ext = CMP_W'(thresh);
        above   = mag_ext > thr_ext;
    end

    xing_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (meas_valid),
        .sel_i   (src_sel),
        .dir_i   (dir_fall),
        .above_i (above),
        .evt_o   (cross_evt)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cross_evt);

endmodule

// File: tb/xing_detect_test.sv
`timescale 1ns/1ps
module xing_detect_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_valid = 1'b0;
    logic [7:0] volt_meas = '0;
    logic [7:0] curr_meas = '0;
    logic       src_sel = 1'b0;
    logic [7:0] thresh = '0;
    logic       dir_fall = 1'b0;
    logic       cross_evt;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    xing_detect uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .volt_meas  (volt_meas),
        .curr_meas  (curr_meas),
        .src_sel    (src_sel),
        .thresh     (thresh),
        .dir_fall   (dir_fall),
        .cross_evt  (cross_evt)
    );

    // {valid, sel, dir, volt, curr, thresh, expected event}
    localparam int NV = 25;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0, 8'd10,  8'd0,   8'd50,  1'b0}, // R11 first sample
        {1'b1,1'b0,1'b0, 8'd60,  8'd0,   8'd50,  1'b1}, // R4 rise
        {1'b1,1'b0,1'b0, 8'd70,  8'd0,   8'd50,  1'b0}, // R6 stays above
        {1'b0,1'b0,1'b0, 8'd5,   8'd0,   8'd50,  1'b0}, // R6 invalid ignored
        {1'b1,1'b0,1'b0, 8'd80,  8'd0,   8'd50,  1'b0}, // R6 history held
        {1'b1,1'b0,1'b0, 8'd50,  8'd0,   8'd50,  1'b0}, // R8 equal not above
        {1'b1,1'b0,1'b0, 8'hCD,  8'd0,   8'd50,  1'b1}, // R3 -51 rises
        {1'b1,1'b0,1'b0, 8'd0,   8'd0,   8'd50,  1'b0},
        {1'b1,1'b0,1'b0, 8'd0,   8'd100, 8'd50,  1'b0}, // R2 current unused
        {1'b1,1'b0,1'b0, 8'd51,  8'h9C,  8'd50,  1'b1}, // R2 voltage rise
        {1'b1,1'b0,1'b0, 8'd0,   8'd0,   8'd50,  1'b0},
        {1'b1,1'b1,1'b0, 8'd0,   8'd100, 8'd50,  1'b0}, // R9 sel change
        {1'b1,1'b1,1'b0, 8'd0,   8'd10,  8'd50,  1'b0},
        {1'b1,1'b1,1'b0, 8'd0,   8'hA6,  8'd50,  1'b1}, // R2 current -90
        {1'b1,1'b1,1'b1, 8'd0,   8'd0,   8'd50,  1'b0}, // R9 dir change
        {1'b1,1'b1,1'b1, 8'd0,   8'd90,  8'd50,  1'b0},
        {1'b1,1'b1,1'b1, 8'd0,   8'd50,  8'd50,  1'b1}, // R5 fall to equal
        {1'b1,1'b1,1'b1, 8'd0,   8'd20,  8'd50,  1'b0}, // R6 stays below
        {1'b1,1'b1,1'b1, 8'd0,   8'h80,  8'd126, 1'b0}, // R7 127 above 126
        {1'b1,1'b1,1'b1, 8'd0,   8'd0,   8'd126, 1'b1}, // R5 fall
        {1'b1,1'b1,1'b0, 8'd0,   8'd0,   8'd126, 1'b0}, // R9 dir change
        {1'b1,1'b1,1'b0, 8'd0,   8'h80,  8'd126, 1'b1}, // R7 rise from -128
        {1'b1,1'b1,1'b0, 8'd0,   8'd0,   8'd127, 1'b0},
        {1'b1,1'b1,1'b0, 8'd0,   8'h80,  8'd127, 1'b0}, // R7 127 not above 127
        {1'b1,1'b1,1'b0, 8'd0,   8'd127, 8'd200, 1'b0}  // R8 thresh >= 128
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: cross_evt=%0b expected %0b at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic d,
                         input logic [7:0] vm, input logic [7:0] cm, input logic [7:0] th);
        meas_valid = v; src_sel = s; dir_fall = d;
        volt_meas = vm; curr_meas = cm; thresh = th;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check(cross_evt, 1'b0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cross_evt, 1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
            @(negedge clk);
            check(cross_evt, VEC[i][0], $sformatf("R4/R5 vector %0d", i));
        end

        // R10: event lasts one cycle with inputs held idle
        drive(1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 8'd40, 8'd0, 8'd30);
        @(negedge clk);
        check(cross_evt, 1'b1, "R10 pulse high");
        drive(1'b0, 1'b0, 1'b0, 8'd40, 8'd0, 8'd30);
        @(negedge clk);
        check(cross_evt, 1'b0, "R10 pulse ends");

        // R9: direction toggled on an idle cycle still clears history
        drive(1'b0, 1'b0, 1'b1, 8'd40, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 8'd40, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 8'd45, 8'd0, 8'd30);
        @(negedge clk);
        check(cross_evt, 1'b1, "R9 reference rebuilt");
        drive(1'b0, 1'b0, 1'b1, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        check(cross_evt, 1'b0, "R9 idle dir change suppresses fall");

        // R1/R11: reset mid-run, first sample afterwards is only a reference
        drive(1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 8'd90, 8'd0, 8'd30);
        @(negedge clk);
        check(cross_evt, 1'b0, "R1 reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        check(cross_evt, 1'b0, "R11 first sample after reset");
        drive(1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd30);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 8'h9C, 8'd0, 8'd30);
        @(negedge clk);
        check(cross_evt, 1'b1, "R3 negative rise after reset");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule